// File: doc/BRIEF.md
# Buffered PWM Timer Channel

A single down-counting pulse-width timer with a shadow copy of its period count and its compare threshold. Software writes the shadow (buffer) registers at any time. The live counter and the live compare only take the buffered values in two cases: while the update control bit is held, or at an underflow when reload is enabled. A period can therefore be retuned while the timer runs without producing a torn cycle.

An 8-bit prescaler produces the tick that steps the counter. The waveform comparator drives a raw output that an invert bit can flip. A dead-time stage then turns that level into a complementary pair, with a programmable guard interval in which both pins are low. An interrupt pulse marks every underflow. Without reload the timer runs once and clears its own run bit.

Top module: `pwm_chan`

## Requirements
- R1: Register map (byte offsets): 0x00 count buffer, 0x04 compare buffer, 0x08 live counter (read only; writes are ignored), 0x0C control with bit0 run, bit1 update, bit2 invert, bit3 reload, 0x10 timing with prescaler in bits [7:0] and dead time in bits [15:8]. Reads are combinational and zero-extended.
- R2: After reset the live counter, control and timing registers read 0, `out_p` is 0, `out_n` is 1 and `irq` is 0.
- R3: Writing a buffer register leaves the live counter untouched. While update is set, every clock loads both buffers into the live registers and holds the counter there, with no decrement and no interrupt, even when run is set.
- R4: With run set and update clear, the counter steps down once per prescaler tick. A tick comes every (prescaler+1) clocks, so the period is (count+1)*(prescaler+1) clocks.
- R5: The raw waveform rises when the counter steps onto the compare value and falls at underflow. It is high for (compare+1)*(prescaler+1) clocks of each period when compare < count. Invert swaps high and low.
- R6: At an underflow with reload set, the counter and compare restart from the buffers. A buffer written during a run takes effect from the next underflow.
- R7: At an underflow with reload clear, the counter stays at 0 and the run bit clears itself.
- R8: Each underflow gives exactly one `irq` clock, in the cycle after the underflow tick. `irq` only follows a counter value of 0.
- R9: Dead time: the output that goes inactive drops 1 clock after the waveform edge. The other output rises dead+2 clocks after it, so both are low for dead+1 clocks and are never high together.
- R10: With run and update both clear, the live counter keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 5 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read byte offset |
| rd_data | output | 32 | Read data (combinational) |
| out_p | output | 1 | Timer output after dead time |
| out_n | output | 1 | Complementary output after dead time |
| irq | output | 1 | One-clock underflow pulse |

## Verification
A register write takes effect at the clock edge that samples it. A held update bit shows in the live counter one edge later. The interrupt follows the underflow tick by one clock. The falling output of the pair moves one clock after a waveform edge and the rising one moves dead+2 clocks after it. The bench therefore never samples at a fixed time after a write. It measures edge-to-edge distances on the output pins over whole periods, counts interrupts over windows that are exact multiples of the period, and first lets each new setting run for several periods so start-up effects have passed. Register reads are sampled on the falling clock edge, after the edge that wrote them.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int OFF_CNTB = 'h00;
  localparam int OFF_CMPB = 'h04;
  localparam int OFF_OBS  = 'h08;
  localparam int OFF_CTRL = 'h0C;
  localparam int OFF_TIME = 'h10;
  localparam int TIME_DZ_LSB = 8;

  typedef struct packed {
    logic reload;
    logic invert;
    logic update;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PRE_W-1:0] pre_val,
  output logic             tick
);
  logic [PRE_W-1:0] pc_q, pc_nxt;

  always_comb begin
    pc_nxt = pc_q;
    if (!en)                 pc_nxt = '0;
    else if (pc_q == pre_val) pc_nxt = '0;
    else                     pc_nxt = pc_q + 1'b1;
  end

  assign tick = en && (pc_q == pre_val);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_nxt;
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             update,
  input  logic             reload,
  input  logic [CNT_W-1:0] cnt_buf,
  input  logic [CNT_W-1:0] cmp_buf,
  output logic [CNT_W-1:0] cnt,
  output logic             raw,
  output logic             uf
);
  logic [CNT_W-1:0] cnt_q, cnt_nxt, cmp_q, cmp_nxt, dec;
  logic             raw_q, raw_nxt;

  assign dec = cnt_q - 1'b1;

  always_comb begin
    cnt_nxt = cnt_q;
    cmp_nxt = cmp_q;
    raw_nxt = raw_q;
    uf      = 1'b0;
    if (update) begin
      cnt_nxt = cnt_buf;
      cmp_nxt = cmp_buf;
      raw_nxt = 1'b0;
    end else if (run && tick) begin
      if (cnt_q == '0) begin
        uf      = 1'b1;
        raw_nxt = 1'b0;
        if (reload) begin
          cnt_nxt = cnt_buf;
          cmp_nxt = cmp_buf;
        end
      end else begin
        cnt_nxt = dec;
        if (dec == cmp_q) raw_nxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      cmp_q <= '0;
      raw_q <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      cmp_q <= cmp_nxt;
      raw_q <= raw_nxt;
    end

  assign cnt = cnt_q;
  assign raw = raw_q;
endmodule

// File: rtl/pwm_deadzone.sv
module pwm_deadzone #(
  parameter int DZ_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            x,
  input  logic [DZ_W-1:0] dz_len,
  output logic            out_p,
  output logic            out_n
);
  logic            lvl_q, lvl_nxt, p_q, p_nxt, n_q, n_nxt;
  logic [DZ_W-1:0] dc_q, dc_nxt;

  always_comb begin
    lvl_nxt = lvl_q;
    dc_nxt  = dc_q;
    p_nxt   = p_q;
    n_nxt   = n_q;
    if (x != lvl_q) begin
      lvl_nxt = x;
      dc_nxt  = dz_len;
      p_nxt   = 1'b0;
      n_nxt   = 1'b0;
    end else if (dc_q != '0) begin
      dc_nxt = dc_q - 1'b1;
    end else begin
      p_nxt = lvl_q;
      n_nxt = ~lvl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lvl_q <= 1'b0;
      dc_q  <= '0;
      p_q   <= 1'b0;
      n_q   <= 1'b1;
    end else begin
      lvl_q <= lvl_nxt;
      dc_q  <= dc_nxt;
      p_q   <= p_nxt;
      n_q   <= n_nxt;
    end

  assign out_p = p_q;
  assign out_n = n_q;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PRE_W  = 8,
  parameter int DZ_W   = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              out_p,
  output logic              out_n,
  output logic              irq
);
  localparam int CTRL_W = $bits(ctrl_t);

  logic [1:0]       rs_q;
  logic             rst_i_n;
  logic [CNT_W-1:0] cntb_q, cntb_nxt, cmpb_q, cmpb_nxt, obs;
  ctrl_t            ctrl_q, ctrl_nxt;
  logic [PRE_W-1:0] pre_q, pre_nxt;
  logic [DZ_W-1:0]  dz_q, dz_nxt;
  logic             irq_q, tick, raw, uf, run_w, upd_w, pre_en;
  logic             unused_wr;

  assign unused_wr = ^wr_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  assign rst_i_n = rs_q[1];

  always_comb begin
    cntb_nxt = cntb_q;
    cmpb_nxt = cmpb_q;
    ctrl_nxt = ctrl_q;
    pre_nxt  = pre_q;
    dz_nxt   = dz_q;
    if (uf && !ctrl_q.reload) ctrl_nxt.run = 1'b0;
    if (wr_en) begin
      case (wr_addr)
        ADDR_W'(OFF_CNTB): cntb_nxt = wr_data[CNT_W-1:0];
        ADDR_W'(OFF_CMPB): cmpb_nxt = wr_data[CNT_W-1:0];
        ADDR_W'(OFF_CTRL): ctrl_nxt = ctrl_t'(wr_data[CTRL_W-1:0]);
        ADDR_W'(OFF_TIME): begin
          pre_nxt = wr_data[PRE_W-1:0];
          dz_nxt  = wr_data[TIME_DZ_LSB +: DZ_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n)
    if (!rst_i_n) begin
      cntb_q <= '0;
      cmpb_q <= '0;
      ctrl_q <= '0;
      pre_q  <= '0;
      dz_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      cntb_q <= cntb_nxt;
      cmpb_q <= cmpb_nxt;
      ctrl_q <= ctrl_nxt;
      pre_q  <= pre_nxt;
      dz_q   <= dz_nxt;
      irq_q  <= uf;
    end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(OFF_CNTB): rd_data = DATA_W'(cntb_q);
      ADDR_W'(OFF_CMPB): rd_data = DATA_W'(cmpb_q);
      ADDR_W'(OFF_OBS):  rd_data = DATA_W'(obs);
      ADDR_W'(OFF_CTRL): rd_data = DATA_W'(ctrl_q);
      ADDR_W'(OFF_TIME): begin
        rd_data[PRE_W-1:0]            = pre_q;
        rd_data[TIME_DZ_LSB +: DZ_W] = dz_q;
      end
      default: ;
    endcase
  end

  assign run_w  = ctrl_q.run;
  assign upd_w  = ctrl_q.update;
  assign pre_en = run_w && !upd_w;

  pwm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_i_n), .en(pre_en), .pre_val(pre_q), .tick(tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_i_n), .tick(tick), .run(run_w), .update(upd_w),
    .reload(ctrl_q.reload), .cnt_buf(cntb_q), .cmp_buf(cmpb_q),
    .cnt(obs), .raw(raw), .uf(uf)
  );

  pwm_deadzone #(.DZ_W(DZ_W)) u_dz (
    .clk(clk), .rst_n(rst_i_n), .x(raw ^ ctrl_q.invert), .dz_len(dz_q),
    .out_p(out_p), .out_n(out_n)
  );

  assign irq = irq_q;
endmodule

// File: rtl/pwm_chan_chk.sv
module pwm_chan_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             update,
  input logic [CNT_W-1:0] cnt_buf,
  input logic [CNT_W-1:0] obs,
  input logic             out_p,
  input logic             out_n,
  input logic             irq
);
  assert_update_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> obs == $past(cnt_buf));

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !update) |=> obs == $past(obs));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !update && obs != '0) |=>
      (obs == $past(obs) || obs == CNT_W'($past(obs) - 1'b1)));

  assert_irq_after_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ($past(obs) == '0 && $past(run)));

  assert_never_both_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_p && out_n));

  assert_p_rise_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_p) |-> !$past(out_n));

  assert_n_rise_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_n) |-> !$past(out_p));
endmodule

bind pwm_chan pwm_chan_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_i_n), .run(run_w), .update(upd_w), .cnt_buf(cntb_q),
  .obs(obs), .out_p(out_p), .out_n(out_n), .irq(irq)
);

// File: tb/pwm_chan_bench.sv
`timescale 1ns/1ps
module pwm_chan_bench;
  logic        clk, rst_n, wr_en;
  logic [4:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic        out_p, out_n, irq;
  int          n_chk, n_err;
  logic        done;

  pwm_chan u_pwm_chan (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .out_p(out_p), .out_n(out_n), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // stimulus vectors: count, compare, prescaler, dead time, invert
  localparam int NV = 4;
  localparam int V_CNT[NV] = '{4, 9, 7, 15};
  localparam int V_CMP[NV] = '{2, 5, 2, 10};
  localparam int V_PRE[NV] = '{1, 0, 2, 0};
  localparam int V_DZ [NV] = '{0, 2, 4, 1};
  localparam int V_INV[NV] = '{0, 0, 1, 1};

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 32'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    rd_addr = 5'(a);
    #1 v = int'(rd_data);
  endtask

  task automatic count_irq(input int cycles, output int c);
    c = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (irq) c++;
    end
  endtask

  task automatic irq_gap(output int g);
    int k = 0, t1 = -1;
    g = -1;
    while (k < 3000 && g < 0) begin
      @(negedge clk); k++;
      if (irq) begin
        if (t1 < 0) t1 = k;
        else g = k - t1;
      end
    end
  endtask

  task automatic measure(output int per, output int hi, output int gap);
    int k = 0, tn = -1, t1 = -1, t2 = -1, t3 = -1;
    logic pp, pn;
    per = -1; hi = -1; gap = -1;
    @(negedge clk); pp = out_p; pn = out_n;
    while (t3 < 0 && k < 3000) begin
      @(negedge clk); k++;
      if (pn && !out_n) tn = k;
      if (!pp && out_p) begin
        if (t1 < 0) t1 = k;
        else if (t2 >= 0) begin t3 = k; gap = k - tn; end
      end
      if (pp && !out_p && t1 >= 0 && t2 < 0) t2 = k;
      pp = out_p; pn = out_n;
    end
    if (t3 >= 0) begin per = t3 - t1; hi = t2 - t1; end
  endtask

  initial begin
    done = 1'b0;
    #1_500_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int v, per, hi, gap, c, p;
    n_chk = 0; n_err = 0;
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    chk("R2 out_p", out_p, 0);
    chk("R2 out_n", out_n, 1);
    chk("R2 irq", irq, 0);
    rd('h08, v); chk("R2 counter", v, 0);
    rd('h0C, v); chk("R2 control", v, 0);

    // vector table: R4 period, R5 duty/invert, R9 dead time, R8 irq rate
    for (int i = 0; i < NV; i++) begin
      p = (V_CNT[i] + 1) * (V_PRE[i] + 1);
      wr('h0C, 0);
      wr('h00, V_CNT[i]);
      wr('h04, V_CMP[i]);
      wr('h10, (V_DZ[i] << 8) | V_PRE[i]);
      wr('h0C, 2 | (V_INV[i] << 2));
      wr('h0C, 1 | 8 | (V_INV[i] << 2));
      repeat (3 * p + 20) @(negedge clk);
      measure(per, hi, gap);
      chk($sformatf("R4 period vec%0d", i), per, p);
      if (V_INV[i] == 0)
        chk($sformatf("R5 high vec%0d", i), hi, (V_CMP[i] + 1) * (V_PRE[i] + 1) - (V_DZ[i] + 1));
      else
        chk($sformatf("R5 inverted high vec%0d", i), hi, p - (V_CMP[i] + 1) * (V_PRE[i] + 1) - (V_DZ[i] + 1));
      chk($sformatf("R9 dead gap vec%0d", i), gap, V_DZ[i] + 1);
      count_irq(4 * p, c);
      chk($sformatf("R8 irq count vec%0d", i), c, 4);
    end

    // R1 register readback
    rd('h04, v); chk("R1 compare buffer readback", v, 10);
    rd('h10, v); chk("R1 timing readback", v, 'h100);

    // R3 update loads, R10 idle hold, R1 write to counter ignored
    wr('h0C, 0);
    wr('h00, 7);
    wr('h0C, 2);
    wr('h0C, 0);
    rd('h08, v); chk("R3 update loads counter", v, 7);
    wr('h00, 9);
    repeat (5) @(negedge clk);
    rd('h08, v); chk("R3 buffer write leaves counter", v, 7);
    wr('h08, 'h55);
    repeat (5) @(negedge clk);
    rd('h08, v); chk("R10 idle hold / R1 counter read only", v, 7);

    // R7 one-shot
    wr('h00, 3);
    wr('h10, 0);
    wr('h0C, 2);
    wr('h0C, 1);
    count_irq(40, c);
    chk("R7 one-shot single irq", c, 1);
    rd('h08, v); chk("R7 counter rests at zero", v, 0);
    rd('h0C, v); chk("R7 run bit self-clears", v, 0);

    // R3 update held with run: counter pinned, no irq
    wr('h0C, 'hB);
    count_irq(30, c);
    chk("R3 held update no irq", c, 0);
    rd('h08, v); chk("R3 held update counter", v, 3);

    // R6 buffer written mid-run applies at next underflow
    wr('h00, 4);
    wr('h04, 1);
    wr('h0C, 2);
    wr('h0C, 9);
    irq_gap(v); chk("R6 initial irq interval", v, 5);
    wr('h00, 6);
    repeat (20) @(negedge clk);
    irq_gap(v); chk("R6 reloaded irq interval", v, 7);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule